// File: doc/BRIEF.md
# Systolic Multiply-Accumulate Window Column

This block is one column of a systolic array for window-based image filtering. It turns a single column read of w + NR − 1 pixels into NR vertically adjacent window results. Every pixel is presented to all NR processing elements in the same cycle. A tagged stream of mask coefficients enters at the top of the column and moves down through one register per element. Element k therefore pairs coefficient i with pixel i + k and produces the window result one image row below its upper neighbour.

Each element is a multiply-accumulate unit. The coefficient tags mark where a window begins and ends, so the window length w is set by the stream and not by a parameter. When a window ends, the element moves its sum into a hold register and can begin a new window in the next cycle. A local collector visits the elements from top to bottom and emits one finished result per cycle, together with the row index of the element that produced it. The coefficient stream leaves the last element, passes through a realignment delay line of NR − 1 stages, and is presented at the bottom for the next column.

Top module: `mac_column`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `res_valid` and `cf_out_valid` are low. The collector always begins at row 0 after reset.
- R2: Count cycles from the cycle that carries the coefficient tagged first (cycle 0). The result of row k is the sum over i of W(i)·P(i+k), where:
  - W(i) is the i-th valid coefficient of the window, taken as 8-bit two's complement;
  - P(t) is the unsigned 8-bit pixel presented in cycle t.
- R3: The outputs `cf_out_*` repeat `cf_valid`, `cf_first`, `cf_last` and `cf_data` exactly 2·NR − 1 clock edges later. This is NR element registers followed by NR − 1 realignment stages.
- R4: Let E be the edge that samples the first coefficient of a window of length w. The result of row k is on the outputs from edge E + w + k until the next edge.
- R5: Results leave in row order 0, 1, …, NR−1, one per cycle. `res_row` carries the row index. `res_valid` is low in every cycle that has no result.
- R6: A new window may begin in the cycle right after the last pixel of the previous strip. Every strip in such a back-to-back stream produces correct results. This includes w = 1.
- R7: Pixels presented while an element holds no valid coefficient do not change that element's result. An example is idle cycles between strips.
- R8: A window of up to 16 taps with pixels of 255 and coefficients of −128 gives the exact sum in the 21-bit signed result, without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Pixel presented to every element |
| cf_valid | input | 1 | Coefficient present this cycle |
| cf_first | input | 1 | Coefficient is the first of a window |
| cf_last | input | 1 | Coefficient is the last of a window |
| cf_data | input | 8 | Signed mask coefficient |
| cf_out_valid | output | 1 | Forwarded coefficient present |
| cf_out_first | output | 1 | Forwarded first tag |
| cf_out_last | output | 1 | Forwarded last tag |
| cf_out_data | output | 8 | Forwarded coefficient value |
| res_valid | output | 1 | A window result is on `res_data` |
| res_row | output | ROW_W | Row index of the element that produced the result |
| res_data | output | 21 | Signed window sum |

## Verification
In a back-to-back stream, two things happen in the same cycles. The collector is still draining the lower rows of one strip while the upper elements are already loading the first coefficients of the next strip. Coefficient forwarding runs in parallel with both. Strips are therefore queued with no gap, including one-tap windows in which every element finishes one cycle after it starts. In every cycle the bench compares the result outputs and the forwarded coefficient against schedules it computes itself from the skew and delay rules. A result that is late, shifted to another row or taken from the wrong strip shows up as a per-cycle mismatch.

// File: rtl/mac_column_pkg.sv
package mac_column_pkg;

    localparam int PIX_W  = 8;
    localparam int COEF_W = 8;
    localparam int KW_MAX = 16;
    localparam int PROD_W = PIX_W + 1 + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(KW_MAX);

    typedef struct packed {
        logic                     vld;
        logic                     first;
        logic                     last;
        logic signed [COEF_W-1:0] val;
    } ctok_t;

    typedef logic signed [ACC_W-1:0] acc_t;

    function automatic acc_t mac_step(input logic [PIX_W-1:0] p,
                                      input logic signed [COEF_W-1:0] c,
                                      input acc_t base,
                                      input logic fresh);
        logic signed [PROD_W-1:0] pr;
        acc_t                     pe;
        pr = PROD_W'($signed({1'b0, p})) * PROD_W'(c);
        pe = ACC_W'(pr);
        return fresh ? pe : base + pe;
    endfunction

endpackage

// File: rtl/mac_column_pe.sv
module mac_column_pe
    import mac_column_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix,
    input  ctok_t            tok_in,
    input  logic             take,
    output ctok_t            tok_out,
    output logic             done,
    output acc_t             result
);
    acc_t acc;
    acc_t nxt;

    always_comb nxt = mac_step(pix, tok_in.val, acc, tok_in.first);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            tok_out <= '0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            tok_out <= tok_in;
            if (tok_in.vld) acc <= nxt;
            if (tok_in.vld && tok_in.last) begin
                done   <= 1'b1;
                result <= nxt;
            end else if (take) begin
                done <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mac_column_dly.sv
module mac_column_dly
    import mac_column_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  ctok_t d,
    output ctok_t q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            ctok_t stg [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/mac_column_coll.sv
module mac_column_coll
    import mac_column_pkg::*;
#(
    parameter int NR    = 4,
    parameter int ROW_W = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NR-1:0]    done,
    input  acc_t             res [NR],
    output logic [NR-1:0]    take,
    output logic             out_valid,
    output logic [ROW_W-1:0] out_row,
    output acc_t             out_data
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NR - 1);

    logic [ROW_W-1:0] ptr;
    logic             hit;

    always_comb begin
        take = '0;
        hit  = done[ptr];
        if (hit) take[ptr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            out_valid <= 1'b0;
            out_row   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= hit;
            if (hit) begin
                out_data <= res[ptr];
                out_row  <= ptr;
                ptr      <= (ptr == LAST_ROW) ? '0 : ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mac_column.sv
module mac_column
    import mac_column_pkg::*;
#(
    parameter int NR    = 4,
    parameter int ROW_W = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic              cf_valid,
    input  logic              cf_first,
    input  logic              cf_last,
    input  logic [COEF_W-1:0] cf_data,
    output logic              cf_out_valid,
    output logic              cf_out_first,
    output logic              cf_out_last,
    output logic [COEF_W-1:0] cf_out_data,
    output logic              res_valid,
    output logic [ROW_W-1:0]  res_row,
    output logic [ACC_W-1:0]  res_data
);
    localparam int DLY = NR - 1;

    ctok_t         chain [NR+1];
    ctok_t         tail;
    logic [NR-1:0] done;
    logic [NR-1:0] take;
    acc_t          res   [NR];
    acc_t          col_data;

    assign chain[0] = '{vld: cf_valid, first: cf_first, last: cf_last,
                        val: $signed(cf_data)};

    generate
        for (genvar k = 0; k < NR; k++) begin : g_pe
            mac_column_pe u_pe (
                .clk    (clk),
                .rst    (rst),
                .pix    (pix_in),
                .tok_in (chain[k]),
                .take   (take[k]),
                .tok_out(chain[k+1]),
                .done   (done[k]),
                .result (res[k])
            );
        end
    endgenerate

    mac_column_dly #(.DEPTH(DLY)) u_dly (
        .clk(clk),
        .rst(rst),
        .d  (chain[NR]),
        .q  (tail)
    );

    mac_column_coll #(.NR(NR), .ROW_W(ROW_W)) u_coll (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .res      (res),
        .take     (take),
        .out_valid(res_valid),
        .out_row  (res_row),
        .out_data (col_data)
    );

    assign res_data     = col_data;
    assign cf_out_valid = tail.vld;
    assign cf_out_first = tail.first;
    assign cf_out_last  = tail.last;
    assign cf_out_data  = tail.val;
endmodule

// File: rtl/mac_column_chk.sv
module mac_column_chk #(
    parameter int NR    = 4,
    parameter int ROW_W = (NR > 1) ? $clog2(NR) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cf_valid,
    input logic             cf_last,
    input logic             cf_out_valid,
    input logic             res_valid,
    input logic [ROW_W-1:0] res_row
);
    logic [15:0]      pend;
    logic [15:0]      owed;
    logic [ROW_W-1:0] want_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            owed     <= '0;
            want_row <= '0;
        end else begin
            pend <= pend + 16'(cf_valid) - 16'(cf_out_valid);
            owed <= owed + ((cf_valid && cf_last) ? 16'(NR) : 16'd0) - 16'(res_valid);
            if (res_valid)
                want_row <= (want_row == ROW_W'(NR - 1)) ? '0 : want_row + 1'b1;
        end
    end

    AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !cf_out_valid)); // R1
    AST_FWD_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        cf_out_valid |-> (pend != 16'd0)); // R3
    AST_RESULT_OWED: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (owed != 16'd0)); // R4
    AST_ROW_ORDER: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_row == want_row)); // R5
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (int'(res_row) < NR)); // R5
endmodule

bind mac_column mac_column_chk #(.NR(NR), .ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cf_valid    (cf_valid),
    .cf_last     (cf_last),
    .cf_out_valid(cf_out_valid),
    .res_valid   (res_valid),
    .res_row     (res_row)
);

// File: tb/mac_column_tb.sv
module mac_column_tb;
    localparam int NR    = 4;
    localparam int ROW_W = 2;
    localparam int FWD   = 2 * NR - 1;
    localparam int SLOTS = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       pix_in = '0;
    logic             cf_valid = 1'b0, cf_first = 1'b0, cf_last = 1'b0;
    logic [7:0]       cf_data = '0;
    logic             cf_out_valid, cf_out_first, cf_out_last;
    logic [7:0]       cf_out_data;
    logic             res_valid;
    logic [ROW_W-1:0] res_row;
    logic [20:0]      res_data;

    int n_cmp = 0;
    int n_bad = 0;

    int     spix [SLOTS];
    int     scf  [SLOTS];
    bit     sv   [SLOTS];
    bit     sf   [SLOTS];
    bit     sl   [SLOTS];
    bit     ev   [SLOTS];
    int     erow [SLOTS];
    longint edat [SLOTS];
    int     plen;

    always #10 clk = ~clk;

    mac_column #(.NR(NR)) u_dut (
        .clk(clk), .rst(rst), .pix_in(pix_in),
        .cf_valid(cf_valid), .cf_first(cf_first), .cf_last(cf_last), .cf_data(cf_data),
        .cf_out_valid(cf_out_valid), .cf_out_first(cf_out_first),
        .cf_out_last(cf_out_last), .cf_out_data(cf_out_data),
        .res_valid(res_valid), .res_row(res_row), .res_data(res_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_plan();
        for (int i = 0; i < SLOTS; i++) begin
            spix[i] = (i * 37 + 11) % 256;
            scf[i] = 0; sv[i] = 0; sf[i] = 0; sl[i] = 0;
            ev[i] = 0; erow[i] = 0; edat[i] = 0;
        end
        plen = 0;
    endtask

    task automatic add_strip(input int start, input int w, input int pa, input int pb,
                             input int ca, input int cb, input bit extreme);
        for (int t = 0; t < w + NR - 1; t++)
            spix[start + t] = extreme ? 255 : (pa * t + pb) % 256;
        for (int i = 0; i < w; i++) begin
            sv[start + i]  = 1;
            sf[start + i]  = (i == 0);
            sl[start + i]  = (i == w - 1);
            scf[start + i] = extreme ? -128 : ((ca * i + cb) % 256) - 128;
        end
        for (int k = 0; k < NR; k++) begin
            longint sum = 0;
            for (int i = 0; i < w; i++)
                sum += longint'(scf[start + i]) * longint'(spix[start + i + k]);
            ev[start + w + k + 1]   = 1;
            erow[start + w + k + 1] = k;
            edat[start + w + k + 1] = sum;
        end
        if (start + w + NR + FWD + 2 > plen) plen = start + w + NR + FWD + 2;
    endtask

    task automatic run_plan(input string tag);
        @(negedge clk);
        rst = 1'b1;
        cf_valid = 0; cf_first = 0; cf_last = 0; cf_data = '0; pix_in = '0;
        repeat (2) @(negedge clk);
        check(!res_valid, "R1", "res_valid in reset", res_valid, 0);
        check(!cf_out_valid, "R1", "cf_out_valid in reset", cf_out_valid, 0);
        rst = 1'b0;
        for (int t = 0; t < plen; t++) begin
            int s;
            pix_in   = spix[t][7:0];
            cf_valid = sv[t];
            cf_first = sf[t];
            cf_last  = sl[t];
            cf_data  = scf[t][7:0];
            @(negedge clk);
            s = t + 1;
            if (s < SLOTS) begin
                if (ev[s]) begin
                    check(res_valid, "R4", $sformatf("%s valid at step %0d", tag, s), res_valid, 1);
                    check(int'(res_row) == erow[s], "R5",
                          $sformatf("%s row at step %0d", tag, s), res_row, erow[s]);
                    check(longint'($signed(res_data)) == edat[s], "R2",
                          $sformatf("%s row %0d data", tag, erow[s]),
                          longint'($signed(res_data)), edat[s]);
                end else begin
                    check(!res_valid, "R5", $sformatf("%s idle at step %0d", tag, s), res_valid, 0);
                end
            end
            if (s >= FWD && s - FWD < SLOTS) begin
                int src = s - FWD;
                check(cf_out_valid == sv[src], "R3",
                      $sformatf("%s fwd valid step %0d", tag, s), cf_out_valid, sv[src]);
                if (sv[src]) begin
                    check(cf_out_first == sf[src] && cf_out_last == sl[src], "R3",
                          $sformatf("%s fwd tags step %0d", tag, s),
                          {cf_out_first, cf_out_last}, {sf[src], sl[src]});
                    check(int'($signed(cf_out_data)) == scf[src], "R3",
                          $sformatf("%s fwd data step %0d", tag, s),
                          $signed(cf_out_data), scf[src]);
                end
            end
        end
        cf_valid = 0; cf_first = 0; cf_last = 0;
    endtask

    initial begin
        clear_plan(); add_strip(0, 3, 1, 5, 7, 3, 0);
        run_plan("R2 single strip w3");
        clear_plan(); add_strip(0, 3, 13, 200, 29, 1, 0);
        add_strip(6, 3, 31, 7, 53, 90, 0); add_strip(12, 3, 3, 250, 11, 255, 0);
        run_plan("R6 back-to-back w3");
        clear_plan(); add_strip(0, 1, 17, 9, 1, 60, 0);
        add_strip(4, 1, 41, 100, 1, 220, 0); add_strip(8, 1, 5, 3, 1, 0, 0);
        run_plan("R6 back-to-back w1");
        clear_plan(); add_strip(0, 2, 19, 40, 77, 130, 0); add_strip(14, 2, 23, 1, 5, 17, 0);
        run_plan("R7 gap with junk pixels");
        clear_plan(); add_strip(0, 5, 0, 0, 0, 0, 1); add_strip(8, 5, 97, 33, 61, 44, 0);
        run_plan("R8 extreme w5");
        clear_plan(); add_strip(0, 16, 0, 0, 0, 0, 1);
        run_plan("R8 extreme w16");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule